// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block produces the control strobes and the data-bus drive for single bus cycles on a NAND flash device. A requester presents one cycle at a time: a command byte, an address byte, a data byte to write, or a data byte to read. The block frames the cycle with the matching latch-enable line, pulses the write or read strobe, keeps the latch lines and the bus stable for a hold time, waits a programmed settling time, and then waits until the device reports ready. It raises a one-clock completion pulse and returns the captured read byte.

All timing comes from a single 32-bit timing word. It holds two groups of four 4-bit fields, one group for reads and one for writes. The fields give the setup, strobe-width and hold lengths, and a ready-sample delay that is counted in pairs of clocks. The timing word is sampled when a cycle is accepted, so the register logic outside the block may change it at any time. Chip enable is not sequenced here. It simply follows a force-low input that the surrounding controller drives.

Top module: `nand_strobe_timer`

## Requirements
- R1: While reset is held and whenever the block is idle, weN and reN are high, cle, ale, busOe and done are low, and reqReady is high.
- R2: A field value v gives a phase of v+1 clocks. The setup phase, from acceptance until the strobe falls, lasts (setup+1) clocks. Write-type cycles take setup from timingCfg[19:16] and reads take it from timingCfg[3:0].
- R3: The strobe stays low for (width+1) clocks. Write-type cycles pulse weN with the width from timingCfg[27:24]. Reads pulse reN with the width from timingCfg[11:8].
- R4: After the strobe rises, the latch line and the bus drive stay as they were for (hold+1) clocks. The hold comes from timingCfg[23:20] for write-type cycles and from timingCfg[7:4] for reads. For a write-type cycle the frame therefore lasts setup+width+hold+3 clocks.
- R5: After the hold phase the block waits 2*n clocks. n comes from timingCfg[31:28] for write-type cycles and from timingCfg[15:12] for reads. It then samples flashRdy every clock. done rises in the clock after the first high sample, which is setup+width+hold+2n+5 clocks after acceptance when flashRdy is already high.
- R6: reqKind encodes the cycle type: 0 = command, 1 = address, 2 = data write, 3 = data read. Only command cycles raise cle and only address cycles raise ale. Kinds 0 to 2 pulse weN only, and kind 3 pulses reN only.
- R7: During the frame of a kind 0 to 2 cycle, busOe is high and busDout equals the accepted reqWdata. busOe stays low for reads.
- R8: rdData takes the value of busDin at the clock edge that ends the read strobe. It keeps that value through later non-read cycles.
- R9: ceN is always the inverse of forceCeLow and never changes because of cycle activity.
- R10: A request is accepted only when reqReady is high. A request raised while a cycle is in progress is ignored, and a change of timingCfg after acceptance has no effect on the running cycle.
- R11: done is high for exactly one clock, and the block is idle in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Cycle request |
| reqKind | input | 2 | Cycle type (0 cmd, 1 addr, 2 write, 3 read) |
| reqWdata | input | DATA_W | Byte to drive for cmd/addr/write cycles |
| timingCfg | input | 8*FIELD_W | Packed timing word |
| reqReady | output | 1 | Block is idle and will accept a request |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Byte captured by the last read cycle |
| forceCeLow | input | 1 | Request chip enable active |
| flashRdy | input | 1 | Device ready (high) / busy (low) |
| busDin | input | DATA_W | Data bus from the device |
| busDout | output | DATA_W | Data bus toward the device |
| busOe | output | 1 | Data bus output enable |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |

## Verification
The bench uses the default DATA_W=8 and FIELD_W=4. With these values every timing field has only sixteen codes, so a sweep of sixteen timing words drives every code of every field, in both the read half and the write half, through all four cycle kinds. The two halves always hold different values, so a swapped field or half shows up as a wrong phase length. Phase lengths, completion time and the captured byte are worked out arithmetically for each cycle. flashRdy is held low for a varying number of extra clocks to show the polling, and one cycle is disturbed by an extra request and a changed timing word while it is running.

// File: rtl/nst_pkg.sv
package nst_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_READ  = 2'd3
  } cycleKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_WAIT,
    ST_POLL,
    ST_DONE
  } phase_t;

  // position of each field inside one half of the timing word
  localparam int FLD_SETUP = 0;
  localparam int FLD_HOLD  = 1;
  localparam int FLD_WIDTH = 2;
  localparam int FLD_RDY   = 3;
  localparam int NUM_FLD   = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic   accept;
    logic   load;
    phase_t loadPhase;
    logic   capture;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic       cntZero;
    logic       rdyZero;
    cycleKind_t kind;
  } dpStat_t;

endpackage

// File: rtl/nst_datapath.sv
module nst_datapath
  import nst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dpCtrl_t                ctl,
  input  cycleKind_t             reqKind,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [8*FIELD_W-1:0]   timingCfg,
  input  logic [DATA_W-1:0]      busDin,
  output dpStat_t                stat,
  output logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData
);

  localparam int HALF_W = NUM_FLD * FIELD_W;
  localparam int CFG_W  = 2 * HALF_W;
  localparam int CNT_W  = FIELD_W + 1;

  logic [HALF_W-1:0] inHalf;
  logic [HALF_W-1:0] heldHalf;
  logic [HALF_W-1:0] curHalf;
  logic [FIELD_W-1:0] fld [NUM_FLD];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;
  cycleKind_t        kindQ;
  logic [DATA_W-1:0] wdataQ;

  // reads use the low half of the word, all other kinds the high half
  assign inHalf  = (reqKind == KIND_READ) ? timingCfg[HALF_W-1:0]
                                          : timingCfg[CFG_W-1:HALF_W];
  assign curHalf = ctl.accept ? inHalf : heldHalf;

  generate
    for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
      assign fld[g] = curHalf[g*FIELD_W +: FIELD_W];
    end
  endgenerate

  always_comb begin
    loadVal = '0;
    unique case (ctl.loadPhase)
      ST_SETUP:  loadVal = CNT_W'(fld[FLD_SETUP]);
      ST_STROBE: loadVal = CNT_W'(fld[FLD_WIDTH]);
      ST_HOLD:   loadVal = CNT_W'(fld[FLD_HOLD]);
      ST_WAIT:   loadVal = {fld[FLD_RDY], 1'b0} - CNT_W'(1);
      default:   loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldHalf <= '0;
      kindQ    <= KIND_CMD;
      wdataQ   <= '0;
      cnt      <= '0;
    end else begin
      if (ctl.accept) begin
        heldHalf <= inHalf;
        kindQ    <= reqKind;
        wdataQ   <= reqWdata;
      end
      if (ctl.load) begin
        cnt <= loadVal;
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (ctl.capture) begin
      rdData <= busDin;
    end
  end

  assign stat.cntZero = (cnt == '0);
  assign stat.rdyZero = (fld[FLD_RDY] == '0);
  assign stat.kind    = kindQ;
  assign wrData       = wdataQ;

endmodule

// File: rtl/nst_ctrl.sv
module nst_ctrl
  import nst_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    flashRdy,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    reqReady,
  output logic    done,
  output logic    weN,
  output logic    reN,
  output logic    cle,
  output logic    ale,
  output logic    busOe
);

  phase_t state;
  phase_t nxtState;
  logic   isRead;
  logic   inFrame;

  assign isRead = (stat.kind == KIND_READ);

  always_comb begin
    ctl      = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.accept    = 1'b1;
          ctl.load      = 1'b1;
          ctl.loadPhase = ST_SETUP;
          nxtState      = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (stat.cntZero) begin
          ctl.load      = 1'b1;
          ctl.loadPhase = ST_STROBE;
          nxtState      = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (stat.cntZero) begin
          ctl.capture   = isRead;
          ctl.load      = 1'b1;
          ctl.loadPhase = ST_HOLD;
          nxtState      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (stat.cntZero) begin
          if (stat.rdyZero) begin
            nxtState = ST_POLL;
          end else begin
            ctl.load      = 1'b1;
            ctl.loadPhase = ST_WAIT;
            nxtState      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (stat.cntZero) nxtState = ST_POLL;
      end
      ST_POLL: begin
        if (flashRdy) nxtState = ST_DONE;
      end
      ST_DONE: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxtState;
  end

  assign inFrame  = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_DONE);
  assign weN      = !((state == ST_STROBE) && !isRead);
  assign reN      = !((state == ST_STROBE) && isRead);
  assign cle      = inFrame && (stat.kind == KIND_CMD);
  assign ale      = inFrame && (stat.kind == KIND_ADDR);
  assign busOe    = inFrame && !isRead;

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [8*FIELD_W-1:0] timingCfg,
  output logic                 reqReady,
  output logic                 done,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 forceCeLow,
  input  logic                 flashRdy,
  input  logic [DATA_W-1:0]    busDin,
  output logic [DATA_W-1:0]    busDout,
  output logic                 busOe,
  output logic                 ceN,
  output logic                 cle,
  output logic                 ale,
  output logic                 weN,
  output logic                 reN
);

  dpCtrl_t ctl;
  dpStat_t stat;

  nst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .flashRdy (flashRdy),
    .stat     (stat),
    .ctl      (ctl),
    .reqReady (reqReady),
    .done     (done),
    .weN      (weN),
    .reN      (reN),
    .cle      (cle),
    .ale      (ale),
    .busOe    (busOe)
  );

  nst_datapath #(
    .DATA_W  (DATA_W),
    .FIELD_W (FIELD_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .reqKind   (cycleKind_t'(reqKind)),
    .reqWdata  (reqWdata),
    .timingCfg (timingCfg),
    .busDin    (busDin),
    .stat      (stat),
    .wrData    (busDout),
    .rdData    (rdData)
  );

  // chip enable is owned by the surrounding controller
  assign ceN = ~forceCeLow;

endmodule

// File: rtl/nst_checker.sv
module nst_checker (
  input logic clk,
  input logic rst_n,
  input logic reqValid,
  input logic reqReady,
  input logic done,
  input logic flashRdy,
  input logic weN,
  input logic reN,
  input logic cle,
  input logic ale,
  input logic busOe
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (weN && reN && !cle && !ale && !busOe && !done));

  p_rdy_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(flashRdy));

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!weN && !reN));

  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  p_we_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !weN |-> busOe);

  p_read_no_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !reN |-> !busOe);

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && reqValid) |=> !reqReady);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && reqReady));

endmodule

bind nand_strobe_timer nst_checker i_nst_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .done     (done),
  .flashRdy (flashRdy),
  .weN      (weN),
  .reN      (reN),
  .cle      (cle),
  .ale      (ale),
  .busOe    (busOe)
);

// File: tb/test_nand_strobe_timer.sv
`timescale 1ns/1ps
module test_nand_strobe_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [7:0]  reqWdata = 8'h00;
  logic [31:0] timingCfg = 32'h0;
  logic        reqReady, done;
  logic [7:0]  rdData;
  logic        forceCeLow = 1'b0;
  logic        flashRdy = 1'b1;
  logic [7:0]  busDin = 8'h00;
  logic [7:0]  busDout;
  logic        busOe, ceN, cle, ale, weN, reN;

  int tests = 0;
  int fails = 0;
  logic [7:0] lastRd = 8'h00;

  always #2 clk = ~clk;

  nand_strobe_timer i_nand_strobe_timer (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqWdata(reqWdata), .timingCfg(timingCfg), .reqReady(reqReady),
    .done(done), .rdData(rdData), .forceCeLow(forceCeLow),
    .flashRdy(flashRdy), .busDin(busDin), .busDout(busDout), .busOe(busOe),
    .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input int rS, input int rH, input int rW, input int rR,
                                        input int wS, input int wH, input int wW, input int wR);
    return {wR[3:0], wW[3:0], wH[3:0], wS[3:0], rR[3:0], rW[3:0], rH[3:0], rS[3:0]};
  endfunction

  task automatic runCycle(input int kind, input logic [31:0] cfg, input logic [7:0] wd,
                          input int rdyHold, input bit poke);
    int base = (kind == 3) ? 0 : 16;
    int S = int'(cfg[base +: 4]);
    int H = int'(cfg[base+4 +: 4]);
    int W = int'(cfg[base+8 +: 4]);
    int R = int'(cfg[base+12 +: 4]);
    int d0 = S + W + H + 2*R + 5;
    int frame = S + W + H + 3;
    int k = 0, first = 0, strobeCnt = 0, wrongCnt = 0;
    int cleCnt = 0, aleCnt = 0, oeCnt = 0, mism = 0, ceBad = 0, doneIdx = 0;
    bit doneSeen = 0;
    logic [7:0] rdExp;
    flashRdy = (rdyHold == 0);
    @(negedge clk);
    reqKind = kind[1:0]; reqWdata = wd; timingCfg = cfg; reqValid = 1'b1; busDin = ~wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneSeen && k < 300) begin
      k++;
      if ((kind == 3) ? !reN : !weN) begin
        if (first == 0) first = k;
        if (kind == 3) busDin = wd + 8'(strobeCnt);
        strobeCnt++;
      end
      if ((kind == 3) ? !weN : !reN) wrongCnt++;
      if (cle) cleCnt++;
      if (ale) aleCnt++;
      if (busOe) begin
        oeCnt++;
        if (busDout != wd) mism++;
      end
      if (ceN != !forceCeLow) ceBad++;
      if (done) begin doneSeen = 1; doneIdx = k; end
      if (rdyHold > 0 && k == d0 - 1 + rdyHold) flashRdy = 1'b1;
      if (poke && k == 2) begin
        reqValid = 1'b1; reqKind = 2'd0; timingCfg = ~cfg;
      end
      if (poke && k == 3) reqValid = 1'b0;
      if (!doneSeen) @(negedge clk);
    end
    chk(first == S + 2, "R2 setup clocks", first - 1, S + 1);
    chk(strobeCnt == W + 1, "R3 strobe width", strobeCnt, W + 1);
    chk(oeCnt == ((kind != 3) ? frame : 0), "R4/R7 bus frame", oeCnt, (kind != 3) ? frame : 0);
    chk(doneIdx == d0 + rdyHold, "R5 done time", doneIdx, d0 + rdyHold);
    chk(cleCnt == ((kind == 0) ? frame : 0), "R6 cle frame", cleCnt, (kind == 0) ? frame : 0);
    chk(aleCnt == ((kind == 1) ? frame : 0), "R6 ale frame", aleCnt, (kind == 1) ? frame : 0);
    chk(wrongCnt == 0, "R6 wrong strobe", wrongCnt, 0);
    chk(mism == 0, "R7 busDout value", mism, 0);
    chk(ceBad == 0, "R9 ceN during cycle", ceBad, 0);
    if (kind == 3) begin
      rdExp = wd + 8'(W);
      lastRd = rdExp;
    end else begin
      rdExp = lastRd;
    end
    chk(rdData == rdExp, "R8 rdData", int'(rdData), int'(rdExp));
    @(negedge clk);
    chk(!done && reqReady, "R11 done one clock", int'(done), 0);
    if (poke) begin
      int noisy = 0;
      for (int i = 0; i < 20; i++) begin
        if (!weN || !reN || cle || ale || !reqReady) noisy++;
        @(negedge clk);
      end
      chk(noisy == 0, "R10 busy request ignored", noisy, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(weN && reN && !cle && !ale && !busOe && !done && reqReady, "R1 reset outputs",
        int'({weN, reN, cle, ale, busOe, done, reqReady}), 7'b1100001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(weN && reN && !cle && !ale && !busOe && reqReady, "R1 idle outputs",
        int'({weN, reN, cle, ale, busOe, reqReady}), 6'b110001);
    // R9: chip enable follows the force input
    forceCeLow = 1'b1;
    #1;
    chk(ceN == 1'b0, "R9 ceN low", int'(ceN), 0);
    forceCeLow = 1'b0;
    #1;
    chk(ceN == 1'b1, "R9 ceN high", int'(ceN), 1);

    // sweep: every field code in both halves over all kinds
    for (int v = 0; v < 16; v++) begin
      logic [31:0] cfg = mkCfg((v*5) % 16, (v+9) % 16, v, 15 - v,
                               v, (v*3) % 16, (v+5) % 16, (v+2) % 16);
      forceCeLow = v[0];
      runCycle(0, cfg, 8'(8'h30 + v), v % 3, 1'b0);
      runCycle(1, cfg, 8'(8'h50 + v), (v+1) % 3, 1'b0);
      runCycle(3, cfg, 8'(8'h10 * v), (v+2) % 3, 1'b0);
      runCycle(2, cfg, 8'(8'hA0 + v), v % 3, 1'b0);
    end

    // R10: request and timing change while busy
    forceCeLow = 1'b0;
    runCycle(1, mkCfg(2, 2, 2, 1, 5, 3, 6, 2), 8'hC3, 1, 1'b1);
    runCycle(3, mkCfg(0, 0, 0, 0, 9, 9, 9, 9), 8'h7E, 0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule